// File: doc/BRIEF.md
# Line Telemetry Serialiser

This block puts the per-line results of a multiplexed feedback controller onto a single-bit link. The link runs at the master clock. A line-sync pulse marks the start of each line. On that pulse the block captures the results of the row just finished: a 14-bit feedback value, a 16-bit error value, an overflow flag and a frame marker. The frame marker is set only when that row was the first row of a frame. During the line that follows, the block sends these results as one 32-cycle packet, so the data on the link always belongs to the previous line.

The packet holds two 16-bit words with no gap between them, each sent MSB first. The feedback word goes first. Its two spare upper bits carry the frame marker and the overflow flag. The error word follows. A valid strobe is high during the 32 data cycles, and both the strobe and the data line are low at all other times. A receiver at the host uses the strobe to frame the words and the frame marker to split the stream back into rows. Lines must last at least 32 clocks. If a line-sync pulse arrives while more than one bit of the current packet is still to be sent, the block drops the rest of that packet, starts the new one, and sets a sticky underrun flag.

Top module: `telem_streamer`

## Requirements
- R1: While reset is asserted, and until the first line-sync after reset, ser_data, ser_valid and underrun are all 0.
- R2: ser_data is 0 in every cycle in which ser_valid is 0.
- R3: A line_sync sampled high at a clock edge makes ser_valid high for the 32 cycles that follow that edge. If no further line_sync arrives, ser_valid falls after those 32 cycles.
- R4: Cycles 1 to 16 of a packet carry the feedback word MSB first. Packet bit 31 is the frame marker, bit 30 is the overflow flag, and bits 29..16 are fb_word[13:0].
- R5: Cycles 17 to 32 of a packet carry err_word[15:0] MSB first, with no idle cycle between the two words.
- R6: The packet carries the input values present at the line_sync edge. Changes to the inputs after that edge do not alter the packet being sent.
- R7: Line-sync pulses spaced exactly 32 cycles apart produce back-to-back packets. ser_valid stays high continuously and underrun is not set.
- R8: A line_sync that arrives while two or more bits of the current packet remain unsent aborts that packet. The new packet begins in the next cycle and underrun is set in that same cycle.
- R9: Once set, underrun stays 1 until reset, whatever the later line traffic. A line_sync that arrives while the link is idle never sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_sync | input | 1 | One-cycle pulse that marks the start of a line |
| fb_word | input | 14 | Feedback value of the previous row |
| err_word | input | 16 | Error value of the previous row |
| fb_ovf | input | 1 | Overflow flag of the previous row |
| frame_first | input | 1 | High when the previous row was the first row of a frame |
| ser_data | output | 1 | Serial data, MSB first |
| ser_valid | output | 1 | High during the 32 data cycles of a packet |
| underrun | output | 1 | Sticky flag: a packet was cut short by an early line-sync |

## Verification
A wrong bit counter changes the packet length. This appears as ser_valid falling early or late, or as a missing or false underrun at the next line_sync, in the same cycle as the fault. A wrong shift register or wrong packing appears at once as a misplaced frame, overflow or data bit within the same packet, and as a non-zero ser_data once ser_valid has fallen. The reference model compares all three outputs on every cycle, so any divergence is reported in the cycle where it first appears.

// File: rtl/telem_pkg.sv
package telem_pkg;

  // Marker bits carried in the spare upper bits of the feedback word.
  localparam int MARK_W = 2;

  typedef struct packed {
    logic frame;
    logic ovf;
  } telem_mark_t;

endpackage

// File: rtl/telem_rst_sync.sv
module telem_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/telem_pack.sv
module telem_pack
  import telem_pkg::*;
#(
  parameter int FB_W   = 14,
  parameter int ERR_W  = 16,
  parameter int WORD_W = 16,
  localparam int PKT_W = 2 * WORD_W
) (
  input  telem_mark_t        mark,
  input  logic [FB_W-1:0]    fb,
  input  logic [ERR_W-1:0]   err,
  output logic [PKT_W-1:0]   packet
);

  localparam int PAD_W  = WORD_W - MARK_W - FB_W;
  localparam int EPAD_W = WORD_W - ERR_W;

  logic [WORD_W-1:0] word_fb;
  logic [WORD_W-1:0] word_err;

  generate
    if (PAD_W > 0) begin : g_fb_pad
      assign word_fb = {mark, {PAD_W{1'b0}}, fb};
    end else begin : g_fb_tight
      assign word_fb = {mark, fb};
    end
    if (EPAD_W > 0) begin : g_err_pad
      assign word_err = {{EPAD_W{1'b0}}, err};
    end else begin : g_err_tight
      assign word_err = err;
    end
  endgenerate

  assign packet = {word_fb, word_err};

endmodule

// File: rtl/telem_beat_ctr.sv
module telem_beat_ctr #(
  parameter int PKT_W = 32,
  localparam int CNT_W = $clog2(PKT_W + 1)
) (
  input  logic clk,
  input  logic srst_n,
  input  logic start,
  output logic busy,
  output logic load_en,
  output logic shift_en,
  output logic underrun
);

  logic [CNT_W-1:0] left_q, left_d;
  logic             und_q, und_d;
  logic             early;

  // Bits still owed when a new line begins: more than the one on the wire.
  assign early = start && (left_q > CNT_W'(1));

  always_comb begin
    left_d = left_q;
    und_d  = und_q | early;
    if (start)                    left_d = CNT_W'(PKT_W);
    else if (left_q != '0)        left_d = left_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      left_q <= '0;
      und_q  <= 1'b0;
    end else begin
      left_q <= left_d;
      und_q  <= und_d;
    end
  end

  assign busy     = (left_q != '0);
  assign load_en  = start;
  assign shift_en = !start && busy;
  assign underrun = und_q;

endmodule

// File: rtl/telem_shifter.sv
module telem_shifter #(
  parameter int PKT_W = 32
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             load_en,
  input  logic             shift_en,
  input  logic [PKT_W-1:0] load_val,
  output logic             bit_out
);

  logic [PKT_W-1:0] sreg_q, sreg_d;

  always_comb begin
    sreg_d = sreg_q;
    if (load_en)       sreg_d = load_val;
    else if (shift_en) sreg_d = {sreg_q[PKT_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) sreg_q <= '0;
    else         sreg_q <= sreg_d;
  end

  assign bit_out = sreg_q[PKT_W-1];

endmodule

// File: rtl/telem_streamer.sv
module telem_streamer
  import telem_pkg::*;
#(
  parameter int FB_W   = 14,
  parameter int ERR_W  = 16,
  parameter int WORD_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_sync,
  input  logic [FB_W-1:0]  fb_word,
  input  logic [ERR_W-1:0] err_word,
  input  logic             fb_ovf,
  input  logic             frame_first,
  output logic             ser_data,
  output logic             ser_valid,
  output logic             underrun
);

  localparam int PKT_W = 2 * WORD_W;

  logic             srst_n;
  logic             load_en, shift_en, busy;
  logic [PKT_W-1:0] packet;
  telem_mark_t      mark;

  assign mark.frame = frame_first;
  assign mark.ovf   = fb_ovf;

  telem_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  telem_pack #(.FB_W(FB_W), .ERR_W(ERR_W), .WORD_W(WORD_W)) u_pack (
    .mark   (mark),
    .fb     (fb_word),
    .err    (err_word),
    .packet (packet)
  );

  telem_beat_ctr #(.PKT_W(PKT_W)) u_ctr (
    .clk      (clk),
    .srst_n   (srst_n),
    .start    (line_sync),
    .busy     (busy),
    .load_en  (load_en),
    .shift_en (shift_en),
    .underrun (underrun)
  );

  telem_shifter #(.PKT_W(PKT_W)) u_shift (
    .clk      (clk),
    .srst_n   (srst_n),
    .load_en  (load_en),
    .shift_en (shift_en),
    .load_val (packet),
    .bit_out  (ser_data)
  );

  assign ser_valid = busy;

endmodule

// File: rtl/telem_chk.sv
module telem_chk #(
  parameter int PKT_W = 32
) (
  input logic clk,
  input logic rst_n,
  input logic line_sync,
  input logic ser_data,
  input logic ser_valid,
  input logic underrun
);

  logic [7:0] run_q;

  // Cycles of the current packet shown so far (1 in its first cycle).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_q <= 8'd0;
    else if (line_sync) run_q <= 8'd1;
    else if (ser_valid) run_q <= run_q + 8'd1;
    else                run_q <= 8'd0;
  end

  assert_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_valid |-> !ser_data);

  assert_sync_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    line_sync |=> ser_valid);

  assert_run_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ser_valid |-> (run_q <= 8'(PKT_W)) && (run_q != 8'd0));

  assert_rise_needs_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_valid) |-> $past(line_sync));

  assert_abort_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (line_sync && ser_valid && run_q < 8'(PKT_W)) |=> underrun);

  assert_exact_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (line_sync && ser_valid && run_q == 8'(PKT_W)) |=> $stable(underrun));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);

endmodule

bind telem_streamer telem_chk #(.PKT_W(2 * WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (srst_n),
  .line_sync (line_sync),
  .ser_data  (ser_data),
  .ser_valid (ser_valid),
  .underrun  (underrun)
);

// File: tb/sim_telem_streamer.sv
`timescale 1ns/1ps
module sim_telem_streamer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        line_sync;
  logic [13:0] fb_word;
  logic [15:0] err_word;
  logic        fb_ovf, frame_first;
  logic        ser_data, ser_valid, underrun;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;
  string cur_req = "R2";

  // Reference model state
  bit exp_q[$];
  bit exp_und;

  always #2.5 clk = ~clk;

  telem_streamer u0 (
    .clk(clk), .rst_n(rst_n), .line_sync(line_sync),
    .fb_word(fb_word), .err_word(err_word), .fb_ovf(fb_ovf),
    .frame_first(frame_first), .ser_data(ser_data),
    .ser_valid(ser_valid), .underrun(underrun)
  );

  // Behavioural model: a queue of the bits still owed on the link.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q.delete();
      exp_und = 1'b0;
    end else if (line_sync) begin
      logic [31:0] p;
      if (exp_q.size() > 1) exp_und = 1'b1;
      p = {frame_first, fb_ovf, fb_word, err_word};
      exp_q.delete();
      for (int i = 31; i >= 0; i--) exp_q.push_back(p[i]);
    end else if (exp_q.size() > 0) begin
      void'(exp_q.pop_front());
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Every-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      bit ev, ed;
      ev = (exp_q.size() > 0);
      ed = ev ? exp_q[0] : 1'b0;
      check(cur_req, "ser_valid", 32'(ser_valid), 32'(ev));
      check(ev ? cur_req : "R2", "ser_data", 32'(ser_data), 32'(ed));
      check(cur_req, "underrun", 32'(underrun), 32'(exp_und));
    end
  end

  task automatic send(input logic [13:0] fb, input logic [15:0] er,
                      input logic fr, input logic ov);
    @(negedge clk);
    fb_word = fb; err_word = er; frame_first = fr; fb_ovf = ov;
    line_sync = 1'b1;
    @(negedge clk);
    line_sync = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; line_sync = 1'b0;
    fb_word = '0; err_word = '0; fb_ovf = 1'b0; frame_first = 1'b0;
    idle(4);
    check("R1", "ser_valid in reset", 32'(ser_valid), 0);
    check("R1", "ser_data in reset",  32'(ser_data),  0);
    check("R1", "underrun in reset",  32'(underrun),  0);
    rst_n = 1'b1;
    idle(6);
    check("R1", "ser_valid after reset", 32'(ser_valid), 0);

    // R4 / R5: field placement and order under several patterns
    cur_req = "R4";
    send(14'h3FFF, 16'h0000, 1'b1, 1'b0);   idle(40);
    send(14'h0000, 16'hFFFF, 1'b0, 1'b1);   idle(40);
    cur_req = "R5";
    send(14'h2AAA, 16'h5A3C, 1'b1, 1'b1);   idle(40);
    send(14'h1234, 16'h8001, 1'b0, 1'b0);   idle(40);

    // R6: inputs change right after the capture edge
    cur_req = "R6";
    send(14'h0F0F, 16'hC3C3, 1'b1, 1'b0);
    fb_word = 14'h3333; err_word = 16'h1111; frame_first = 1'b0; fb_ovf = 1'b1;
    idle(40);

    // R7: exact 32-cycle period
    cur_req = "R7";
    send(14'h0001, 16'h0002, 1'b1, 1'b0);
    for (int k = 0; k < 4; k++) begin
      idle(30);
      send(14'(k * 97), 16'(k * 4093 + 7), 1'b0, k[0]);
    end
    idle(40);
    check("R7", "underrun after exact period", 32'(underrun), 0);

    // R9: sync while idle never sets underrun
    cur_req = "R9";
    send(14'h0555, 16'h0AAA, 1'b0, 1'b0);   idle(40);
    check("R9", "underrun after idle sync", 32'(underrun), 0);

    // R8: period of 31 and period of 20 abort the packet
    cur_req = "R8";
    send(14'h1111, 16'h2222, 1'b1, 1'b0);
    idle(29);
    send(14'h3333, 16'h4444, 1'b0, 1'b1);
    check("R8", "underrun after 31-cycle period", 32'(underrun), 1);
    idle(18);
    send(14'h2BCD, 16'hEF01, 1'b1, 1'b1);
    idle(40);

    // R9: sticky through normal traffic
    cur_req = "R9";
    send(14'h0042, 16'h0099, 1'b0, 1'b0);   idle(40);
    check("R9", "underrun held", 32'(underrun), 1);
    rst_n = 1'b0;
    idle(2);
    check("R9", "underrun cleared by reset", 32'(underrun), 0);
    rst_n = 1'b1;
    idle(6);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule